// File: doc/BRIEF.md
# Attribute-Based Raster Video Generator

This block produces the raster timing and the pixel colour stream for a bitmap display. The bitmap is 8·COLS by 8·ROWS pixels (256×192 by default) and one attribute byte covers each 8×8 cell. A border of programmable width surrounds the bitmap. Display memory is read on only one of every two master-clock cycles, so the other cycle is always free for a processor sharing the same memory. For each cell the block fetches a bitmap byte and an attribute byte one cell ahead of display. It then shifts the bitmap bits out, most significant first, and colours each one with the ink or paper colour of its attribute.

Each pixel period lasts two master clocks. The phase-0 cycle is the video memory slot and the phase-1 cycle ends the pixel. A line-doubled VGA mode scans every line twice. A PAL mode scans each line once and carries composite sync on the horizontal sync pin. The border colour comes from an external 3-bit latch. A flash counter advances once per frame and periodically swaps ink and paper in cells whose flash bit is set.

The fetch sequencer has four states. IDLE waits outside the fetch window. BMP issues the bitmap read. ATTR issues the attribute read. WAIT covers the remaining six pixels of the cell. The transitions are:
- IDLE→BMP on the last pixel before a window cell.
- BMP→ATTR and ATTR→WAIT after one pixel each.
- WAIT→BMP at the end of a cell when another window cell follows.
- WAIT→IDLE at the end of the last window cell.

Top module: `attr_video_gen`

## Requirements
- R1: While reset is low, the colour pins, bright_o, hsync_o, vsync_o and mem_req_o are 0 and blank_o is 1. The first pixel period after reset is position h=0, v=0, and the master-clock phase is 0.
- R2: A line has H_TOTAL = H_LB + 8·COLS + H_RB + H_BL pixel periods of two master clocks each. The outputs for horizontal position h change at the clock edge that ends that pixel period. hsync is high for h in [H_LB+8·COLS+H_RB+HS_OFF, +HS_LEN).
- R3: The display line is v/2. In VGA mode (vga_mode_i=1) v steps by 1 up to 2·LINES−1. In PAL mode v steps by 2 up to 2·LINES−2. v returns to 0 only at the end of a line's last pixel. vsync is high on lines in [visible lines+VS_OFF, +VS_LEN).
- R4: blank_o is 1, and the colour pins and bright_o are 0, outside the visible area (h ≥ H_LB+8·COLS+H_RB, or line ≥ V_TB+8·ROWS+V_BB).
- R5: mem_req_o is high only in phase-0 cycles and never in two consecutive cycles. For each cell x of a bitmap line, the bitmap byte is requested at h = H_LB−8+8x and the attribute byte at the next pixel. Read data is taken one clock after the request.
- R6: The bitmap address for pixel row y (line − V_TB) and cell x is {y[7:6], y[2:0], y[5:3], x[4:0]}.
- R7: The attribute address is ATTR_BASE + 32·y[7:3] + x, with ATTR_BASE = 0x1800 by default.
- R8: Within the bitmap, bit 7 of a bitmap byte is the leftmost pixel. A set bit shows ink (attribute bits 2:0) and a clear bit shows paper (bits 5:3). bright_o equals attribute bit 6. A colour code c drives b_o=c[0], r_o=c[1] and g_o=c[2].
- R9: A FLASH_W-bit flash counter is cleared by reset and increments when v wraps to 0. While its top bit is set, cells with attribute bit 7 set swap ink and paper.
- R10: Visible pixels outside the bitmap show border_i as sampled at the end of that pixel, with bright_o 0.
- R11: In PAL mode hsync_o is hsync OR vsync. In VGA mode it is hsync alone. vsync_o is vsync in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vga_mode_i | input | 1 | 1 = line-doubled VGA, 0 = PAL composite sync |
| border_i | input | 3 | Border colour code from external latch |
| mem_req_o | output | 1 | Display memory read strobe (phase-0 cycles only) |
| mem_addr_o | output | ADDR_W | Display memory byte address |
| mem_rdata_i | input | 8 | Read data, valid one clock after the request |
| r_o | output | 1 | Red (colour code bit 1) |
| g_o | output | 1 | Green (colour code bit 2) |
| b_o | output | 1 | Blue (colour code bit 0) |
| bright_o | output | 1 | Bright intensity |
| hsync_o | output | 1 | Horizontal sync, or composite sync in PAL mode |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | High outside the visible area |

## Verification
The bench builds the block with a 2×2-cell bitmap, a 16-pixel left border, an 8-pixel right border and an 8-pixel blanking interval, giving 48 pixels per line. The frame has 2+16+2 visible lines and 4 blank lines, 24 lines in all. This shrinks a frame to a few thousand clocks. Every pixel, every memory slot and both sync pulses of each frame can then be compared against arithmetic expectations. It also allows 34 PAL frames, enough for the flash counter's top bit to rise and the ink/paper swap to be seen, followed by VGA frames that exercise line doubling and the odd vertical top value.

// File: rtl/attr_video_pkg.sv
package attr_video_pkg;
    typedef enum logic [1:0] {
        F_IDLE,
        F_BMP,
        F_ATTR,
        F_WAIT
    } fetch_state_t;

    typedef struct packed {
        logic       flash;
        logic       bright;
        logic [2:0] paper;
        logic [2:0] ink;
    } cell_attr_t;
endpackage

// File: rtl/vid_timing.sv
module vid_timing #(
    parameter int COLS   = 32,
    parameter int ROWS   = 24,
    parameter int H_LB   = 48,
    parameter int H_RB   = 48,
    parameter int H_BL   = 96,
    parameter int HS_OFF = 16,
    parameter int HS_LEN = 32,
    parameter int V_TB   = 48,
    parameter int V_BB   = 56,
    parameter int V_VB   = 16,
    parameter int VS_OFF = 4,
    parameter int VS_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vga_mode,
    output logic       phase,
    output logic       pix_ce,
    output logic       frame_wrap,
    output logic       vis,
    output logic       bmp_area,
    output logic       hs,
    output logic       vs,
    output logic       cell_pre,
    output logic       sub_last,
    output logic [4:0] cell_x,
    output logic [7:0] row_y
);
    localparam int ACT_W   = COLS * 8;
    localparam int ACT_H   = ROWS * 8;
    localparam int H_VIS   = H_LB + ACT_W + H_RB;
    localparam int H_TOTAL = H_VIS + H_BL;
    localparam int V_VIS   = V_TB + ACT_H + V_BB;
    localparam int LINES   = V_VIS + V_VB;
    localparam int HW      = ($clog2(H_TOTAL) < 8) ? 8 : $clog2(H_TOTAL);
    localparam int VCW     = $clog2(2 * LINES);
    localparam int FS      = H_LB - 8;
    localparam int FE      = H_LB + ACT_W - 8;

    logic [HW-1:0]  hcount;
    logic [VCW-1:0] vcount;
    int             line;
    logic           h_last;
    logic           v_top;
    logic           bmp_v;

    assign line   = int'(vcount) / 2;
    assign h_last = (int'(hcount) == H_TOTAL - 1);
    assign v_top  = vga_mode ? (int'(vcount) >= 2 * LINES - 1)
                             : (int'(vcount) >= 2 * LINES - 2);
    assign pix_ce = phase;
    assign frame_wrap = pix_ce && h_last && v_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            hcount <= '0;
            vcount <= '0;
        end else begin
            phase <= ~phase;
            if (pix_ce) begin
                if (h_last) begin
                    hcount <= '0;
                    if (v_top) vcount <= '0;
                    else       vcount <= vcount + (vga_mode ? VCW'(1) : VCW'(2));
                end else begin
                    hcount <= hcount + HW'(1);
                end
            end
        end
    end

    always_comb begin
        bmp_v    = (line >= V_TB) && (line < V_TB + ACT_H);
        vis      = (int'(hcount) < H_VIS) && (line < V_VIS);
        bmp_area = bmp_v && (int'(hcount) >= H_LB) && (int'(hcount) < H_LB + ACT_W);
        hs       = (int'(hcount) >= H_VIS + HS_OFF) && (int'(hcount) < H_VIS + HS_OFF + HS_LEN);
        vs       = (line >= V_VIS + VS_OFF) && (line < V_VIS + VS_OFF + VS_LEN);
        sub_last = (hcount[2:0] == 3'd7);
        cell_pre = sub_last && bmp_v && (int'(hcount) + 1 >= FS) && (int'(hcount) + 1 < FE);
        cell_x   = 5'((int'(hcount) - FS) / 8);
        row_y    = 8'(line - V_TB);
    end

    AST_VWRAP_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (vcount == '0 && $past(vcount) != '0) |-> (int'($past(hcount)) == H_TOTAL - 1)); // R3
endmodule

// File: rtl/vid_fetch.sv
module vid_fetch
    import attr_video_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int ATTR_BASE = 'h1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              pix_ce,
    input  logic              cell_pre,
    input  logic              sub_last,
    input  logic [4:0]        cell_x,
    input  logic [7:0]        row_y,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              load,
    output logic [7:0]        bmp_q,
    output cell_attr_t        attr_q
);
    fetch_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: if (cell_pre) state_d = F_BMP;
            F_BMP:  state_d = F_ATTR;
            F_ATTR: state_d = F_WAIT;
            F_WAIT: begin
                if (cell_pre)      state_d = F_BMP;
                else if (sub_last) state_d = F_IDLE;
            end
            default: state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= F_IDLE;
        else if (pix_ce) state_q <= state_d;
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        load     = 1'b0;
        unique case (state_q)
            F_BMP: begin
                mem_req  = ~phase;
                mem_addr = ADDR_W'({row_y[7:6], row_y[2:0], row_y[5:3], cell_x});
            end
            F_ATTR: begin
                mem_req  = ~phase;
                mem_addr = ADDR_W'(ATTR_BASE + 32 * int'(row_y[7:3]) + int'(cell_x));
            end
            F_WAIT: load = pix_ce && sub_last;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bmp_q  <= '0;
            attr_q <= '0;
        end else if (pix_ce) begin
            if (state_q == F_BMP)  bmp_q  <= mem_rdata;
            if (state_q == F_ATTR) attr_q <= cell_attr_t'(mem_rdata);
        end
    end

    AST_REQ_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R5
    AST_ATTR_AFTER_BMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_ATTR && $past(state_q) != F_ATTR) |-> $past(state_q) == F_BMP); // R5
endmodule

// File: rtl/vid_pixel.sv
module vid_pixel
    import attr_video_pkg::*;
#(
    parameter int FLASH_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_ce,
    input  logic       load,
    input  logic [7:0] bmp_q,
    input  cell_attr_t attr_q,
    input  logic       vis,
    input  logic       bmp_area,
    input  logic       hs,
    input  logic       vs,
    input  logic       frame_wrap,
    input  logic       vga_mode,
    input  logic [2:0] border,
    output logic       r_o,
    output logic       g_o,
    output logic       b_o,
    output logic       bright_o,
    output logic       hsync_o,
    output logic       vsync_o,
    output logic       blank_o
);
    logic [7:0]         shift_q;
    cell_attr_t         cur_q;
    logic [FLASH_W-1:0] flash_q;
    logic               pix_on;
    logic [2:0]         code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cur_q   <= '0;
            flash_q <= '0;
        end else begin
            if (frame_wrap) flash_q <= flash_q + FLASH_W'(1);
            if (pix_ce) begin
                if (load) begin
                    shift_q <= bmp_q;
                    cur_q   <= attr_q;
                end else if (bmp_area) begin
                    shift_q <= {shift_q[6:0], 1'b0};
                end
            end
        end
    end

    assign pix_on = shift_q[7] ^ (cur_q.flash & flash_q[FLASH_W-1]);
    assign code   = pix_on ? cur_q.ink : cur_q.paper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {g_o, r_o, b_o} <= 3'b000;
            bright_o <= 1'b0;
            hsync_o  <= 1'b0;
            vsync_o  <= 1'b0;
            blank_o  <= 1'b1;
        end else if (pix_ce) begin
            if (!vis) begin
                {g_o, r_o, b_o} <= 3'b000;
                bright_o <= 1'b0;
            end else if (bmp_area) begin
                {g_o, r_o, b_o} <= code;
                bright_o <= cur_q.bright;
            end else begin
                {g_o, r_o, b_o} <= border;
                bright_o <= 1'b0;
            end
            blank_o <= ~vis;
            hsync_o <= vga_mode ? hs : (hs | vs);
            vsync_o <= vs;
        end
    end

    AST_FLASH_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_q != $past(flash_q)) |-> (flash_q == $past(flash_q) + FLASH_W'(1))); // R9
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> !(r_o | g_o | b_o | bright_o)); // R4
endmodule

// File: rtl/attr_video_gen.sv
module attr_video_gen
    import attr_video_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int ROWS      = 24,
    parameter int H_LB      = 48,
    parameter int H_RB      = 48,
    parameter int H_BL      = 96,
    parameter int HS_OFF    = 16,
    parameter int HS_LEN    = 32,
    parameter int V_TB      = 48,
    parameter int V_BB      = 56,
    parameter int V_VB      = 16,
    parameter int VS_OFF    = 4,
    parameter int VS_LEN    = 4,
    parameter int FLASH_W   = 5,
    parameter int ADDR_W    = 14,
    parameter int ATTR_BASE = 'h1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vga_mode_i,
    input  logic [2:0]        border_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              r_o,
    output logic              g_o,
    output logic              b_o,
    output logic              bright_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o
);
    logic       phase, pix_ce, frame_wrap, vis, bmp_area, hs, vs;
    logic       cell_pre, sub_last, load;
    logic [4:0] cell_x;
    logic [7:0] row_y, bmp_q;
    cell_attr_t attr_q;

    vid_timing #(
        .COLS(COLS), .ROWS(ROWS), .H_LB(H_LB), .H_RB(H_RB), .H_BL(H_BL),
        .HS_OFF(HS_OFF), .HS_LEN(HS_LEN), .V_TB(V_TB), .V_BB(V_BB),
        .V_VB(V_VB), .VS_OFF(VS_OFF), .VS_LEN(VS_LEN)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .vga_mode(vga_mode_i),
        .phase(phase), .pix_ce(pix_ce), .frame_wrap(frame_wrap),
        .vis(vis), .bmp_area(bmp_area), .hs(hs), .vs(vs),
        .cell_pre(cell_pre), .sub_last(sub_last),
        .cell_x(cell_x), .row_y(row_y)
    );

    vid_fetch #(
        .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .phase(phase), .pix_ce(pix_ce),
        .cell_pre(cell_pre), .sub_last(sub_last),
        .cell_x(cell_x), .row_y(row_y), .mem_rdata(mem_rdata_i),
        .mem_req(mem_req_o), .mem_addr(mem_addr_o),
        .load(load), .bmp_q(bmp_q), .attr_q(attr_q)
    );

    vid_pixel #(
        .FLASH_W(FLASH_W)
    ) u_pixel (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .load(load),
        .bmp_q(bmp_q), .attr_q(attr_q), .vis(vis), .bmp_area(bmp_area),
        .hs(hs), .vs(vs), .frame_wrap(frame_wrap), .vga_mode(vga_mode_i),
        .border(border_i), .r_o(r_o), .g_o(g_o), .b_o(b_o),
        .bright_o(bright_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .blank_o(blank_o)
    );
endmodule

// File: tb/sim_attr_video_gen.sv
module sim_attr_video_gen;
    localparam int COLS = 2, ROWS = 2, H_LB = 16, H_RB = 8, H_BL = 8;
    localparam int HS_OFF = 2, HS_LEN = 3;
    localparam int V_TB = 2, V_BB = 2, V_VB = 4, VS_OFF = 1, VS_LEN = 2;
    localparam int ACT_W = COLS * 8, ACT_H = ROWS * 8;
    localparam int H_VIS = H_LB + ACT_W + H_RB, HT = H_VIS + H_BL;
    localparam int V_VIS = V_TB + ACT_H + V_BB, LINES = V_VIS + V_VB;
    localparam int FS = H_LB - 8, FE = H_LB + ACT_W - 8;

    logic clk = 1'b0, rst_n = 1'b0, vga_mode_i = 1'b0;
    logic [2:0] border_i = 3'd0;
    logic mem_req_o;
    logic [13:0] mem_addr_o;
    logic [7:0] mem_rdata_i = 8'd0;
    logic r_o, g_o, b_o, bright_o, hsync_o, vsync_o, blank_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mem [0:16383];

    always #4 clk = ~clk;

    attr_video_gen #(
        .COLS(COLS), .ROWS(ROWS), .H_LB(H_LB), .H_RB(H_RB), .H_BL(H_BL),
        .HS_OFF(HS_OFF), .HS_LEN(HS_LEN), .V_TB(V_TB), .V_BB(V_BB),
        .V_VB(V_VB), .VS_OFF(VS_OFF), .VS_LEN(VS_LEN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .vga_mode_i(vga_mode_i), .border_i(border_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .r_o(r_o), .g_o(g_o), .b_o(b_o), .bright_o(bright_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
    );

    always @(posedge clk) mem_rdata_i <= mem_req_o ? mem[mem_addr_o] : 8'h00;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bmp_addr(int y, int x);
        return (((y >> 6) & 3) << 11) | ((y & 7) << 8) | (((y >> 3) & 7) << 5) | x;
    endfunction

    function automatic int attr_addr(int y, int x);
        return 'h1800 + (y / 8) * 32 + x;
    endfunction

    task automatic check_mem(int h, int vc, int ph);
        int line = vc / 2;
        bit win = (ph == 0) && line >= V_TB && line < V_TB + ACT_H && h >= FS && h < FE;
        int y = line - V_TB, x = (h - FS) / 8;
        if (win && (h % 8) == 0) begin
            chk("R5 req bitmap slot", int'(mem_req_o), 1);
            chk("R6 bitmap address", int'(mem_addr_o), bmp_addr(y, x));
        end else if (win && (h % 8) == 1) begin
            chk("R5 req attribute slot", int'(mem_req_o), 1);
            chk("R7 attribute address", int'(mem_addr_o), attr_addr(y, x));
        end else begin
            chk("R5 no request", int'(mem_req_o), 0);
        end
    endtask

    task automatic check_video(int h, int vc, int bord, int fc, bit vga);
        int line = vc / 2;
        bit vis = h < H_VIS && line < V_VIS;
        bit hs = h >= H_VIS + HS_OFF && h < H_VIS + HS_OFF + HS_LEN;
        bit vs = line >= V_VIS + VS_OFF && line < V_VIS + VS_OFF + VS_LEN;
        int col = {g_o, r_o, b_o};
        chk("R4 blank", int'(blank_o), int'(!vis));
        chk("R3 vsync", int'(vsync_o), int'(vs));
        if (vga) chk("R2 hsync", int'(hsync_o), int'(hs));
        else     chk("R11 composite sync", int'(hsync_o), int'(hs | vs));
        if (!vis) begin
            chk("R4 dark colour", col, 0);
            chk("R4 dark bright", int'(bright_o), 0);
        end else if (line >= V_TB && line < V_TB + ACT_H && h >= H_LB && h < H_LB + ACT_W) begin
            int y = line - V_TB, px = h - H_LB;
            int bm = mem[bmp_addr(y, px / 8)];
            int at = mem[attr_addr(y, px / 8)];
            bit on = bm[7 - (px % 8)];
            bit swp = at[7] && fc >= 16;
            int exp = ((on ^ swp) != 0) ? (at & 7) : ((at >> 3) & 7);
            if (swp) chk("R9 flashed colour", col, exp);
            else     chk("R8 pixel colour", col, exp);
            chk("R8 bright", int'(bright_o), (at >> 6) & 1);
        end else begin
            chk("R10 border colour", col, bord);
            chk("R10 border bright", int'(bright_o), 0);
        end
    endtask

    task automatic run(bit vga, int frames);
        int h = 0, vc = 0, ph = 0, fc = 0, nfr = 0;
        int p_h = 0, p_vc = 0, p_b = 0, p_fc = 0;
        bit have = 0;
        int top = vga ? 2 * LINES - 1 : 2 * LINES - 2;
        rst_n = 1'b0;
        vga_mode_i = vga;
        repeat (3) @(negedge clk);
        chk("R1 reset colour", int'({g_o, r_o, b_o}), 0);
        chk("R1 reset bright", int'(bright_o), 0);
        chk("R1 reset syncs", int'({hsync_o, vsync_o}), 0);
        chk("R1 reset blank", int'(blank_o), 1);
        chk("R1 reset request", int'(mem_req_o), 0);
        rst_n = 1'b1;
        while (nfr < frames) begin
            if (ph == 0 && h == 0 && vc == 0) border_i = 3'((nfr * 3 + 1) % 8);
            check_mem(h, vc, ph);
            if (ph == 0 && have) check_video(p_h, p_vc, p_b, p_fc, vga);
            if (ph == 1) begin
                p_h = h; p_vc = vc; p_b = int'(border_i); p_fc = fc; have = 1;
                if (h == HT - 1) begin
                    h = 0;
                    if (vc >= top) begin
                        vc = 0; fc = (fc + 1) % 32; nfr++;
                    end else begin
                        vc += vga ? 1 : 2;
                    end
                end else begin
                    h++;
                end
            end
            ph ^= 1;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = 8'((i * 73 + (i >> 3) * 29 + 5) ^ (i >> 6));
        @(negedge clk);
        run(1'b0, 34);
        run(1'b1, 2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule